// File: doc/BRIEF.md
# Atomic Clock Source Select with Half-Step Divider

This block is a clock root that takes one of eight input clocks and divides it by a ratio that can move in steps of one half. Software stages a new source and a new divider code in a configuration word. It then sets a commit bit in a command word. The block moves to the new pair in a single switch, so the output never runs on an old source with a new ratio, or the other way round. The block clears the commit bit once the output runs again at the new setting.

All logic runs on one system clock, `clk`. The input clocks are synchronised and their edges detected, and the selected source's edges (both rising and falling) step a phase counter. For a divider code `c`, one output period spans `c+1` half-periods of the source. The output is high for the first `ceil((c+1)/2)` of them and low for the rest. A switch waits for a low output phase and holds the output low. It then loads the new pair and lets one full half-period of the new source pass before the first new high phase begins. The register bus is a plain write strobe with a combinational read; it has no flow control.

Top module: `clkroot_hdiv`

## Requirements
- R1: After reset, the command word reads 0 and the configuration word reads 0. The output runs from source 0 as a pass-through: its period is 2 half-periods of source 0 and it is high for 1 of them.
- R2: The command word is at offset 0x0: bit 0 is the commit request, bit 4 is the pending flag and bit 31 is the output-held-off flag. The configuration word is at offset 0x4: the source select is in bits 10:8 and the divider code is in bits 4:0. All other bits read 0. Any other offset reads 0, and writes to it change nothing.
- R3: A configuration write sets the pending flag and reads back at once. The output keeps its old period until a commit is requested.
- R4: Writing 1 to command bit 0 starts a commit. Writing 0 there has no effect. Bit 0 reads 1 until the switch is complete. It then drops in the same cycle as the pending flag, and at that moment the output is high at the start of its first new period.
- R5: Away from a switch, the output period equals (code+1) half-periods of the selected source, and the output is high for ceil((code+1)/2) of them.
- R6: Divider code 0 behaves exactly like code 1.
- R7: During a switch, every high pulse has either the old width or the new width. No pulse, high or low, is shorter than one half-period of the fastest source. The active source and divider change only while the output is held off.
- R8: While the output is held low for a switch, command bit 31 reads 1.
- R9: Configuration writes made while a commit is outstanding are ignored. The staged value reads back unchanged.
- R10: A commit completes within 16·Hold + 2·Hnew + 8 cycles of `clk`. Here Hold and Hnew are the half-periods, in `clk` cycles, of the old and the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; registers, synchronisers and divider |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for `bus_addr` (combinational) |
| src_clk | input | 8 | Candidate input clocks, index = source select code |
| clk_out | output | 1 | Divided root clock |

## Verification
If the divider phase counter holds a wrong value, the next high or low phase has the wrong width. The error shows within one output period as a period or high-time mismatch. If the sequencer loads the active pair at the wrong moment, a high pulse appears with neither the old nor the new width, or a low gap appears that is shorter than two system cycles. This shows on the first pulse after the commit. If the command flags are sequenced wrongly, a commit bit stays set past the R10 bound, or the held-off flag is never seen while polling. Either is reported within that one commit.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
  // Field layout of the configuration word (neighbouring software decodes it)
  localparam int SRC_W   = 3;
  localparam int SRC_LSB = 8;
  localparam int DIV_W   = 5;
  localparam int DIV_LSB = 0;
  localparam int NSRC    = 1 << SRC_W;
  localparam int CNT_W   = DIV_W + 1;

  // Command word bit positions
  localparam int UPD_BIT   = 0;
  localparam int DIRTY_BIT = 4;
  localparam int OFF_BIT   = 31;

  // Byte offsets
  localparam int OFS_CMD = 0;
  localparam int OFS_CFG = 4;

  typedef enum logic [1:0] {
    SW_RUN,
    SW_WAIT_LOW,
    SW_GATED,
    SW_SETTLE
  } sw_state_e;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } clk_cfg_t;
endpackage

// File: rtl/hdiv_regs.sv
module hdiv_regs
  import hdiv_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              commit_i,
  input  logic              root_off_i,
  output clk_cfg_t          staged_o,
  output logic              upd_o,
  output logic              dirty_o
);
  logic hit_cmd, hit_cfg;
  logic unused_wbits;

  assign hit_cmd      = (addr_i == ADDR_W'(OFS_CMD));
  assign hit_cfg      = (addr_i == ADDR_W'(OFS_CFG));
  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_o <= '0;
      upd_o    <= 1'b0;
      dirty_o  <= 1'b0;
    end else begin
      if (commit_i) begin
        upd_o   <= 1'b0;
        dirty_o <= 1'b0;
      end else if (we_i && hit_cmd && wdata_i[UPD_BIT]) begin
        upd_o <= 1'b1;
      end
      // staging is frozen while a commit is outstanding
      if (we_i && hit_cfg && !upd_o) begin
        staged_o.src <= wdata_i[SRC_LSB +: SRC_W];
        staged_o.div <= wdata_i[DIV_LSB +: DIV_W];
        dirty_o      <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_cmd) begin
      rdata_o[UPD_BIT]   = upd_o;
      rdata_o[DIRTY_BIT] = dirty_o;
      rdata_o[OFF_BIT]   = root_off_i;
    end else if (hit_cfg) begin
      rdata_o[SRC_LSB +: SRC_W] = staged_o.src;
      rdata_o[DIV_LSB +: DIV_W] = staged_o.div;
    end
  end
endmodule

// File: rtl/hdiv_edge.sv
module hdiv_edge #(
  parameter int N     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] edge_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic [DEPTH-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[DEPTH-2:0], src_i[i]};
    end
    // either polarity of transition counts as one half-period step
    assign edge_o[i] = sh_q[DEPTH-1] ^ sh_q[DEPTH-2];
  end
endmodule

// File: rtl/hdiv_div.sv
module hdiv_div
  import hdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);
  logic [CNT_W-1:0] n_len, hi_len, last, cnt_q, cnt_nx;

  always_comb begin
    n_len  = (div_i == '0) ? CNT_W'(2) : CNT_W'(div_i) + CNT_W'(1);
    hi_len = (n_len + CNT_W'(1)) >> 1;
    last   = n_len - CNT_W'(1);
    cnt_nx = (cnt_q == last) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(1);
      clk_o <= 1'b0;
    end else if (load_i) begin
      cnt_q <= last;
      clk_o <= 1'b0;
    end else if (adv_i) begin
      cnt_q <= cnt_nx;
      clk_o <= (cnt_nx < hi_len);
    end
  end
endmodule

// File: rtl/hdiv_switch.sv
module hdiv_switch
  import hdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd_i,
  input  logic     clk_out_i,
  input  logic     edge_i,
  input  clk_cfg_t staged_i,
  output clk_cfg_t act_o,
  output logic     adv_o,
  output logic     load_o,
  output logic     commit_o,
  output logic     root_off_o
);
  sw_state_e st_q, st_nx;

  always_comb begin
    st_nx    = st_q;
    commit_o = 1'b0;
    unique case (st_q)
      SW_RUN:      if (upd_i) st_nx = SW_WAIT_LOW;
      SW_WAIT_LOW: if (!clk_out_i && !edge_i) st_nx = SW_GATED;
      SW_GATED:    if (edge_i) st_nx = SW_SETTLE;
      SW_SETTLE:   if (edge_i) begin
        st_nx    = SW_RUN;
        commit_o = 1'b1;
      end
      default:     st_nx = SW_RUN;
    endcase
  end

  assign adv_o      = edge_i && (st_q != SW_GATED);
  assign load_o     = (st_q == SW_GATED);
  assign root_off_o = (st_q == SW_GATED) || (st_q == SW_SETTLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SW_RUN;
      act_o <= '0;
    end else begin
      st_q <= st_nx;
      if (st_q == SW_WAIT_LOW && st_nx == SW_GATED) act_o <= staged_i;
    end
  end
endmodule

// File: rtl/clkroot_hdiv.sv
module clkroot_hdiv
  import hdiv_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_clk,
  output logic              clk_out
);
  clk_cfg_t          staged_cfg, act_cfg;
  logic              upd_q, dirty_q, root_off, commit, adv, load, sel_edge;
  logic [NSRC-1:0]   edge_v;

  hdiv_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .commit_i(commit),
    .root_off_i(root_off), .staged_o(staged_cfg), .upd_o(upd_q),
    .dirty_o(dirty_q)
  );

  hdiv_edge #(.N(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_clk), .edge_o(edge_v)
  );

  assign sel_edge = edge_v[act_cfg.src];

  hdiv_switch u_sw (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_q), .clk_out_i(clk_out),
    .edge_i(sel_edge), .staged_i(staged_cfg), .act_o(act_cfg),
    .adv_o(adv), .load_o(load), .commit_o(commit), .root_off_o(root_off)
  );

  hdiv_div u_div (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .load_i(load),
    .div_i(act_cfg.div), .clk_o(clk_out)
  );
endmodule

// File: rtl/hdiv_chk.sv
module hdiv_chk
  import hdiv_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_out,
  input logic              upd,
  input logic              dirty,
  input logic              root_off,
  input logic              sel_edge,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input clk_cfg_t          staged,
  input clk_cfg_t          act
);
  AST_HELD_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    root_off |-> !clk_out);                                   // R8
  AST_OUT_STEPS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_out) |-> $past(sel_edge));                   // R5
  AST_COMMIT_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd) |-> (clk_out && !dirty));                      // R4
  AST_SWAP_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act) |-> root_off);                              // R7
  AST_STAGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && bus_we && bus_addr == ADDR_W'(OFS_CFG)) |=> $stable(staged)); // R9
endmodule

bind clkroot_hdiv hdiv_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_out(clk_out), .upd(upd_q), .dirty(dirty_q),
  .root_off(root_off), .sel_edge(sel_edge), .bus_we(bus_we),
  .bus_addr(bus_addr), .staged(staged_cfg), .act(act_cfg)
);

// File: tb/sim_clkroot_hdiv.sv
module sim_clkroot_hdiv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  src_clk = '0;
  logic        clk_out;

  clkroot_hdiv u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_clk(src_clk),
    .clk_out(clk_out)
  );

  always #10 clk = ~clk;   // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_vec = 0, n_bad = 0;
  int hi_a = 2, hi_b = 2;            // permitted high widths right now
  int cur_h = 2, cur_per = 4, cur_hi = 2;

  typedef struct {int per; int hi; string req;} exp_t;
  exp_t sb_q[$];

  function automatic int half_of(int s); return 2 + s; endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); bus_addr = 4'(a); #1 d = bus_rdata;
  endtask

  task automatic expect_run(int per, int hi, string req);
    exp_t e;
    e.per = per; e.hi = hi; e.req = req;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
  endtask

  // source i toggles every 2+i system cycles, starting after reset
  initial begin
    int cnt [8];
    foreach (cnt[i]) cnt[i] = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        cnt[i]++;
        if (cnt[i] == half_of(i)) begin src_clk[i] = ~src_clk[i]; cnt[i] = 0; end
      end
    end
  end

  // scoreboard monitor: one full period per expected item
  initial begin
    forever begin
      exp_t e;
      int r1, f1, r2;
      wait (sb_q.size() != 0);
      e = sb_q[0];
      @(negedge clk);
      while (clk_out !== 1'b0) @(negedge clk);
      while (clk_out !== 1'b1) @(negedge clk);
      r1 = cyc;
      while (clk_out !== 1'b0) @(negedge clk);
      f1 = cyc;
      while (clk_out !== 1'b1) @(negedge clk);
      r2 = cyc;
      chk(r2 - r1 == e.per, e.req, "period", r2 - r1, e.per);
      chk(f1 - r1 == e.hi, e.req, "high time", f1 - r1, e.hi);
      void'(sb_q.pop_front());
    end
  end

  // pulse monitor R7: no short pulse, no mixed-width high pulse
  initial begin
    logic lvl;
    int run;
    bit armed;
    armed = 1'b0;
    wait (rst_n);
    @(negedge clk);
    lvl = clk_out; run = 1;
    forever begin
      @(negedge clk);
      if (clk_out === lvl) run++;
      else begin
        if (armed) begin
          chk(run >= 2, "R7", "pulse width", run, 2);
          if (lvl === 1'b1)
            chk(run == hi_a || run == hi_b, "R7", "high pulse old/new", run, hi_b);
        end
        armed = 1'b1;
        lvl = clk_out; run = 1;
      end
    end
  end

  task automatic commit(int s, int d, bit poke);
    logic [31:0] v, cfgw;
    int n, hn, pn, t0, lim;
    bit saw_off;
    n  = (d == 0) ? 2 : d + 1;
    hn = ((n + 1) / 2) * half_of(s);
    pn = n * half_of(s);
    cfgw = (32'(s) << 8) | 32'(d);
    wr(4, cfgw);
    rd(0, v);
    chk(v == 32'h10, "R3", "cmd pending after cfg write", v, 32'h10);
    rd(4, v);
    chk(v == cfgw, "R2", "cfg readback", v, cfgw);
    expect_run(cur_per, cur_hi, "R3");       // old rate until commit
    lim = 16 * cur_h + 2 * half_of(s) + 8;
    hi_b = hn;
    wr(0, 32'h1);
    t0 = cyc;
    saw_off = 1'b0;
    if (poke) begin
      wr(4, cfgw ^ 32'h0000_0101);
      rd(4, v);
      chk(v == cfgw, "R9", "cfg write during commit ignored", v, cfgw);
    end
    rd(0, v);
    chk(v[0] == 1'b1 || v[31] == 1'b1, "R4", "commit bit set while busy", v[0], 1);
    while (v[0] == 1'b1 && (cyc - t0) < lim + 50) begin
      if (v[31]) saw_off = 1'b1;
      rd(0, v);
    end
    chk((cyc - t0) <= lim, "R10", "commit latency", cyc - t0, lim);
    chk(saw_off, "R8", "held-off flag seen", saw_off, 1);
    chk(v == 32'h0, "R4", "cmd after commit", v, 0);
    hi_a = hn; hi_b = hn;
    cur_h = half_of(s); cur_per = pn; cur_hi = hn;
    expect_run(pn, hn, (d < 2) ? "R6" : "R5");
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 150000; wd++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", wd, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rd(0, v); chk(v == 0, "R1", "cmd after reset", v, 0);
    rd(4, v); chk(v == 0, "R1", "cfg after reset", v, 0);
    rd(8, v); chk(v == 0, "R2", "unmapped read", v, 0);
    expect_run(4, 2, "R1");
    wr(0, 32'h0);
    rd(0, v); chk(v == 0, "R4", "write 0 to commit bit ignored", v, 0);
    expect_run(4, 2, "R4");
    commit(1, 3, 1'b0);
    commit(2, 2, 1'b1);
    commit(7, 31, 1'b0);
    commit(0, 0, 1'b0);
    commit(4, 1, 1'b0);
    commit(4, 0, 1'b0);
    commit(5, 4, 1'b1);
    commit(3, 6, 1'b0);
    wr(8, 32'hFFFF_FFFF);
    rd(4, v); chk(v == 32'h306, "R2", "unmapped write leaves cfg", v, 32'h306);
    rd(0, v); chk(v == 0, "R2", "unmapped write leaves cmd", v, 0);
    expect_run(cur_per, cur_hi, "R2");
    // commit with nothing staged: same pair re-applied
    wr(0, 32'h1);
    rd(0, v);
    while (v[0] == 1'b1) rd(0, v);
    chk(v == 0, "R4", "bare commit completes", v, 0);
    expect_run(35, 20, "R5");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule